// File: doc/BRIEF.md
# Bit-Serial CRC Engine

This block computes a cyclic redundancy check over a serial bit stream, with the polynomial and the register width set by parameters. While the data-enable input is high, the register takes in one message bit per rising clock edge, most significant bit first. The full remainder is visible on a parallel output. When the enable drops, the same register becomes a shifter: every following clock moves the remainder one place toward its top, filling with zeros, and the serial output always shows the current top bit. The remainder can therefore be appended to the outgoing stream right behind the message.

A typical use is one instance configured for a 7-bit check over command frames and another configured for a 16-bit check over data blocks on a memory-card link. Once a full readout is done the register has returned to zero, so the next message can start at once. A synchronous clear restarts a message early, and a synchronous active-high reset returns the register to zero and overrides both clear and enable.

Top module: `crc_serial_engine`

## Requirements
- R1: A clock edge with `rst` high loads zero into the register, whatever `clr`, `data_en` and `data_in` are at that edge.
- R2: A clock edge with `clr` high and `rst` low loads zero into the register, even when `data_en` is high at that edge.
- R3: On each edge with `data_en` high and no reset or clear, the register takes in `data_in`. Starting from zero, the register holds the remainder of the message bits (first bit taken as the highest power), multiplied by x^WIDTH, modulo the polynomial. `POLY` lists the coefficients below x^WIDTH, with bit i being the coefficient of x^i.
- R4: In the cycle after the last absorbing edge, `crc_par` holds the complete remainder, with bit WIDTH-1 as its highest-order bit.
- R5: `crc_ser` always equals the register's top bit. Each edge with `data_en`, `clr` and `rst` low shifts the register one place toward its top and fills bit 0 with zero. The remainder therefore leaves the serial output highest-order bit first.
- R6: After WIDTH readout edges the register is zero and stays zero through further readout edges. A new message then needs no clear.
- R7: With WIDTH 7 and polynomial x^7+x^3+1 (`POLY` = 7'h09), the 40-bit message 0x11_0000_0900 gives the remainder 7'b0110011. The same message followed by those 7 bits gives zero.
- R8: With WIDTH 16 and polynomial x^16+x^12+x^5+1 (`POLY` = 16'h1021), the message 0x1234567890ABCDEF gives 0x2FBC, and ten bytes of 0xF0 give 0x63E2. Each message followed by its own remainder gives zero.
- R9: With the 16-bit configuration, 4096 consecutive one bits give 0x7FA1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, highest priority |
| clr | input | 1 | Synchronous clear that starts a new message |
| data_en | input | 1 | High: absorb `data_in`; low: shift the remainder out |
| data_in | input | 1 | Message bit, sampled while `data_en` is high |
| crc_par | output | WIDTH | Parallel view of the register |
| crc_ser | output | 1 | Serial remainder output, the register's top bit |

## Verification
The bench builds two instances that share the same inputs: one with WIDTH 7 and `POLY` 7'h09, the other with WIDTH 16 and `POLY` 16'h1021. Because they share inputs, every message gives known remainders for one width while the other width is compared against the model at the same time. The 16-edge readout used for both instances shows the 7-bit one draining to zero and then staying there for nine more edges. The 16-bit configuration brings the long all-ones block and the remainder-appended zero checks within reach, and the 7-bit one brings the short command-frame check.

// File: rtl/crc_pkg.sv
package crc_pkg;

    // Operation the register performs at the next edge
    typedef enum logic [1:0] {
        CRC_OP_ZERO   = 2'd0,
        CRC_OP_ABSORB = 2'd1,
        CRC_OP_DRAIN  = 2'd2
    } crc_op_e;

    // Decoded control word carried to the register stage
    typedef struct packed {
        crc_op_e op;
        logic    bit_in;
    } crc_ctrl_t;

    // Priority: reset, then clear, then enable; otherwise drain
    function automatic crc_op_e crc_pick_op(input logic rst, input logic clr,
                                            input logic en);
        if (rst || clr) begin
            return CRC_OP_ZERO;
        end
        if (en) begin
            return CRC_OP_ABSORB;
        end
        return CRC_OP_DRAIN;
    endfunction

endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
    import crc_pkg::*;
(
    input  logic      rst,
    input  logic      clr,
    input  logic      data_en,
    input  logic      data_in,
    output crc_ctrl_t ctrl
);

    always_comb begin
        ctrl.op     = crc_pick_op(rst, clr, data_en);
        ctrl.bit_in = data_in & data_en;
    end

endmodule

// File: rtl/crc_lfsr_step.sv
module crc_lfsr_step #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY  = 'h1021
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             bit_in,
    output logic [WIDTH-1:0] absorb_nxt,
    output logic [WIDTH-1:0] drain_nxt
);

    logic fb;

    assign fb = bit_in ^ cur[WIDTH-1];

    // One XOR stage per register bit; taps only where POLY has a one
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            if (POLY[0]) begin : g_tap
                assign absorb_nxt[0] = fb;
            end else begin : g_notap
                assign absorb_nxt[0] = 1'b0;
            end
        end else begin : g_up
            if (POLY[i]) begin : g_tap
                assign absorb_nxt[i] = cur[i-1] ^ fb;
            end else begin : g_notap
                assign absorb_nxt[i] = cur[i-1];
            end
        end
    end

    assign drain_nxt = {cur[WIDTH-2:0], 1'b0};

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg
    import crc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             data_en,
    input  logic             data_in,
    input  crc_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] absorb_nxt,
    input  logic [WIDTH-1:0] drain_nxt,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        unique case (ctrl.op)
            CRC_OP_ABSORB: q <= absorb_nxt;
            CRC_OP_DRAIN:  q <= drain_nxt;
            default:       q <= '0;
        endcase
    end

    // R1
    rst_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R3
    zero_absorb_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && data_en && !data_in && q == '0) |=> (q == '0));

    // R6
    drained_stays_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !data_en && q == '0) |=> (q == '0));

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_pkg::*;
#(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY  = 'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             data_en,
    input  logic             data_in,
    output logic [WIDTH-1:0] crc_par,
    output logic             crc_ser
);

    localparam int TOP = WIDTH - 1;

    crc_ctrl_t        ctrl;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] absorb_nxt;
    logic [WIDTH-1:0] drain_nxt;

    crc_ctrl u_ctrl (
        .rst     (rst),
        .clr     (clr),
        .data_en (data_en),
        .data_in (data_in),
        .ctrl    (ctrl)
    );

    crc_lfsr_step #(
        .WIDTH (WIDTH),
        .POLY  (POLY)
    ) u_step (
        .cur        (state_q),
        .bit_in     (ctrl.bit_in),
        .absorb_nxt (absorb_nxt),
        .drain_nxt  (drain_nxt)
    );

    crc_state_reg #(
        .WIDTH (WIDTH)
    ) u_reg (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .data_en    (data_en),
        .data_in    (data_in),
        .ctrl       (ctrl),
        .absorb_nxt (absorb_nxt),
        .drain_nxt  (drain_nxt),
        .q          (state_q)
    );

    assign crc_par = state_q;
    assign crc_ser = state_q[TOP];

    // R5
    shift_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !data_en) |=> (crc_ser == $past(crc_par[TOP-1])));

endmodule

// File: tb/crc_serial_engine_bench.sv
module crc_serial_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        data_en = 1'b0;
    logic        data_in = 1'b0;
    logic [6:0]  par7;
    logic        ser7;
    logic [15:0] par16;
    logic        ser16;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m7  = '0;
    logic [31:0] m16 = '0;
    string phase = "R1";

    always #10 clk = ~clk;

    crc_serial_engine #(.WIDTH(7), .POLY(7'h09)) u_crc_serial_engine_7 (
        .clk(clk), .rst(rst), .clr(clr), .data_en(data_en), .data_in(data_in),
        .crc_par(par7), .crc_ser(ser7)
    );

    crc_serial_engine #(.WIDTH(16), .POLY(16'h1021)) u_crc_serial_engine (
        .clk(clk), .rst(rst), .clr(clr), .data_en(data_en), .data_in(data_in),
        .crc_par(par16), .crc_ser(ser16)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural division step: remainder of (e*x + b*x^w) mod P
    function automatic logic [31:0] model_step(input logic [31:0] e, input logic b,
                                               input int w, input logic [31:0] poly);
        logic [32:0] t;
        t = {e, 1'b0} ^ (33'(b) << w);
        if (t[w]) t = t ^ (33'(poly) | (33'd1 << w));
        return t[31:0] & ((32'd1 << w) - 1);
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] e, input int w,
                                               input logic [31:0] poly);
        if (rst || clr) return '0;
        if (data_en) return model_step(e, data_in, w, poly);
        return (e << 1) & ((32'd1 << w) - 1);
    endfunction

    task automatic tick();
        @(posedge clk);
        m7  = model_next(m7, 7, 32'h09);
        m16 = model_next(m16, 16, 32'h1021);
        @(negedge clk);
        chk(par7 == m7[6:0], phase, 32'(par7), m7);
        chk(ser7 == m7[6], phase, 32'(ser7), 32'(m7[6]));
        chk(par16 == m16[15:0], phase, 32'(par16), m16);
        chk(ser16 == m16[15], phase, 32'(ser16), 32'(m16[15]));
    endtask

    task automatic feed(input logic [127:0] v, input int n);
        phase = "R3";
        for (int i = n - 1; i >= 0; i--) begin
            data_en = 1'b1;
            data_in = v[i];
            tick();
        end
        data_en = 1'b0;
        data_in = 1'b0;
    endtask

    // 16 readout edges; checks the serial bits of one instance against a known value
    task automatic readout(input logic [31:0] known, input int w, input bit wide);
        phase = "R5";
        for (int k = 0; k < 16; k++) begin
            logic exp_bit;
            logic act_bit;
            exp_bit = (k < w) ? known[w-1-k] : 1'b0;
            act_bit = wide ? ser16 : ser7;
            chk(act_bit == exp_bit, "R5 serial order", 32'(act_bit), 32'(exp_bit));
            tick();
        end
        // R6: both drained to zero, no clear used
        chk(par7 == '0, "R6 drained 7", 32'(par7), 32'd0);
        chk(par16 == '0, "R6 drained 16", 32'(par16), 32'd0);
    endtask

    initial begin
        // R1: reset wins over clear and enable
        clr = 1'b1;
        data_en = 1'b1;
        data_in = 1'b1;
        tick();
        tick();
        chk(par7 == '0, "R1 reset 7", 32'(par7), 32'd0);
        chk(par16 == '0, "R1 reset 16", 32'(par16), 32'd0);
        rst = 1'b0;
        clr = 1'b0;
        data_en = 1'b0;
        data_in = 1'b0;
        tick();

        // R7 / R4: short command frame
        feed(128'h11_0000_0900, 40);
        chk(par7 == 7'b0110011, "R7 R4 frame remainder", 32'(par7), 32'h33);
        readout(32'h33, 7, 1'b0);
        feed({40'h11_0000_0900, 7'b0110011}, 47);
        chk(par7 == '0, "R7 appended zero", 32'(par7), 32'd0);
        readout(32'h0, 7, 1'b0);

        // R8 / R4: 16-bit vectors
        feed(128'h1234567890ABCDEF, 64);
        chk(par16 == 16'h2FBC, "R8 R4 word remainder", 32'(par16), 32'h2FBC);
        readout(32'h2FBC, 16, 1'b1);
        feed(128'h1234567890ABCDEF_2FBC, 80);
        chk(par16 == '0, "R8 appended zero", 32'(par16), 32'd0);
        readout(32'h0, 16, 1'b1);
        feed(128'hF0F0F0F0F0F0F0F0F0F0, 80);
        chk(par16 == 16'h63E2, "R8 F0 remainder", 32'(par16), 32'h63E2);
        readout(32'h63E2, 16, 1'b1);
        feed(128'hF0F0F0F0F0F0F0F0F0F0_63E2, 96);
        chk(par16 == '0, "R8 F0 appended zero", 32'(par16), 32'd0);
        readout(32'h0, 16, 1'b1);

        // R9: long all-ones block
        phase = "R3";
        for (int i = 0; i < 4096; i++) begin
            data_en = 1'b1;
            data_in = 1'b1;
            tick();
        end
        data_en = 1'b0;
        data_in = 1'b0;
        chk(par16 == 16'h7FA1, "R9 all-ones remainder", 32'(par16), 32'h7FA1);
        readout(32'h7FA1, 16, 1'b1);

        // R2: clear mid-message, with enable still high
        feed(128'hA5C3, 16);
        phase = "R2";
        clr = 1'b1;
        data_en = 1'b1;
        data_in = 1'b1;
        tick();
        chk(par7 == '0, "R2 clear 7", 32'(par7), 32'd0);
        chk(par16 == '0, "R2 clear 16", 32'(par16), 32'd0);
        clr = 1'b0;
        data_en = 1'b0;
        data_in = 1'b0;
        feed(128'h1234567890ABCDEF, 64);
        chk(par16 == 16'h2FBC, "R2 fresh after clear", 32'(par16), 32'h2FBC);

        // R1: reset mid-message
        feed(128'h3C, 8);
        phase = "R1";
        rst = 1'b1;
        data_en = 1'b1;
        data_in = 1'b1;
        tick();
        chk(par7 == '0, "R1 mid reset 7", 32'(par7), 32'd0);
        chk(par16 == '0, "R1 mid reset 16", 32'(par16), 32'd0);
        rst = 1'b0;
        data_en = 1'b0;
        data_in = 1'b0;
        tick();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule